// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst request into a stream of DRAM column addresses, one per clock. A request gives a starting column, a burst length of four or eight, and an ordering mode, either sequential or interleaved. The block then presents one column address per beat with a valid strobe, and raises a marker on the final beat. Every address in a burst stays inside the aligned group of columns whose size equals the burst length. Only the low bits move, and they wrap inside that group.

Length and ordering are captured when the request is accepted and hold until the burst ends. A request made on the final beat of a burst starts the next burst on the following clock, so bursts can run back to back with no idle cycle. A request made on any earlier beat is dropped.

Top module: `burst_col_seq`

## Requirements
- R1: While rst_ni is low, and at the first sample after reset, valid_o and last_o are 0.
- R2: When start_i is high and no burst is active, the next cycle shows valid_o=1 and col_o equal to col_i as it was when the request was accepted (beat 0).
- R3: In a burst of 4 with ilv_i=0 (sequential), the low two bits on beat b are (start[1:0] + b) mod 4.
- R4: In a burst of 4 with ilv_i=1 (interleaved), the low two bits on beat b are start[1:0] XOR b.
- R5: In a burst of 8 with ilv_i=0, the low two bits on beat b are (start[1:0] + b[1:0]) mod 4, and bit 2 is start[2] XOR b[2]. Each 4-column half therefore wraps on its own.
- R6: In a burst of 8 with ilv_i=1, the low three bits on beat b are start[2:0] XOR b.
- R7: Column bits from bit 2 up (burst of 4, len8_i=0) or from bit 3 up (burst of 8, len8_i=1) equal those of the start column on every beat.
- R8: last_o is high only on beat 3 of a burst of 4 or beat 7 of a burst of 8. If start_i is low on the last beat, valid_o is 0 on the next cycle.
- R9: If start_i is high on the last beat, the next cycle shows beat 0 of the new request with valid_o=1, with no idle cycle in between.
- R10: start_i, col_i, len8_i and ilv_i have no effect on any beat of an active burst other than its last beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Burst request |
| col_i | input | COL_W | Starting column address |
| len8_i | input | 1 | Burst length: 1 selects 8 beats, 0 selects 4 beats |
| ilv_i | input | 1 | Ordering: 1 selects interleaved, 0 selects sequential |
| col_o | output | COL_W | Column address for the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Final beat of the burst |

## Verification
A new request and the final beat of the running burst can fall in the same cycle. The next burst must then take over from beat 0 with its own freshly captured length and order, and none of the old burst's settings may carry over. The bench provokes this by chaining random bursts back to back at random. On a chained burst it checks beat 0 and the full sequence that follows against a model of the new request. Requests made on earlier beats use different parameters, and the checks confirm that the running burst's addresses are unchanged.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int unsigned MAX_BL = 8;
  localparam int unsigned BEAT_W = $clog2(MAX_BL);

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } ord_e;
endpackage

// File: rtl/bcs_order.sv
module bcs_order
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0]  base_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic              len8_i,
  input  ord_e              ord_i,
  output logic [COL_W-1:0]  col_o
);
  logic [1:0] lo2;
  logic       bit2;

  always_comb begin
    if (ord_i == ORD_ILV) lo2 = base_i[1:0] ^ beat_i[1:0];
    else                  lo2 = base_i[1:0] + beat_i[1:0];
    // both orders flip bit 2 on the second half of an 8-beat burst
    bit2 = len8_i ? (base_i[2] ^ beat_i[2]) : base_i[2];
    col_o = {base_i[COL_W-1:3], bit2, lo2};
  end
endmodule

// File: rtl/bcs_beat_ctrl.sv
module bcs_beat_ctrl
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              len8_i,
  input  logic              ilv_i,
  output logic              act_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              last_o,
  output logic [COL_W-1:0]  base_o,
  output logic              len8_o,
  output ord_e              ord_o
);
  localparam logic [BEAT_W-1:0] LAST4 = BEAT_W'(3);
  localparam logic [BEAT_W-1:0] LAST8 = BEAT_W'(MAX_BL - 1);

  logic accept;

  assign last_o = act_o && (beat_o == (len8_o ? LAST8 : LAST4));
  assign accept = start_i && (!act_o || last_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o  <= 1'b0;
      beat_o <= '0;
      base_o <= '0;
      len8_o <= 1'b0;
      ord_o  <= ORD_SEQ;
    end else if (accept) begin
      act_o  <= 1'b1;
      beat_o <= '0;
      base_o <= col_i;
      len8_o <= len8_i;
      ord_o  <= ilv_i ? ORD_ILV : ORD_SEQ;
    end else if (act_o) begin
      if (last_o) act_o <= 1'b0;
      else        beat_o <= beat_o + 1'b1;
    end
  end

  p_beat_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o && !last_o) |=> (act_o && beat_o == $past(beat_o) + 1'b1));

  p_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !act_o);

  p_chain_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && start_i) |=> (act_o && beat_o == '0 && base_o == $past(col_i)));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o && !last_o) |=> ($stable(base_o) && $stable(len8_o) && $stable(ord_o)));
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             len8_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic              act;
  logic [BEAT_W-1:0] beat;
  logic [COL_W-1:0]  base;
  logic              len8_q;
  ord_e              ord_q;

  bcs_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .col_i  (col_i),
    .len8_i (len8_i),
    .ilv_i  (ilv_i),
    .act_o  (act),
    .beat_o (beat),
    .last_o (last_o),
    .base_o (base),
    .len8_o (len8_q),
    .ord_o  (ord_q)
  );

  bcs_order #(.COL_W(COL_W)) u_order (
    .base_i(base),
    .beat_i(beat),
    .len8_i(len8_q),
    .ord_i (ord_q),
    .col_o (col_o)
  );

  assign valid_o = act;

  p_last_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  p_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o) |=>
      (col_o[COL_W-1:3] == $past(col_o[COL_W-1:3]) &&
       (len8_q || col_o[2] == $past(col_o[2]))));

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !valid_o) |=> (valid_o && col_o == $past(col_i)));
endmodule

// File: tb/tb_burst_col_seq.sv
`timescale 1ns/1ps
module tb_burst_col_seq;
  localparam int COL_W = 10;
  localparam int NB    = 80;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [COL_W-1:0] col_in;
  logic             len8;
  logic             ilv;
  logic [COL_W-1:0] col_out;
  logic             valid;
  logic             last;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .start_i(start),
    .col_i  (col_in),
    .len8_i (len8),
    .ilv_i  (ilv),
    .col_o  (col_out),
    .valid_o(valid),
    .last_o (last)
  );

  function automatic int exp_col(int base, bit l8, bit il, int b);
    int lo, nib;
    if (il) lo = (base ^ b) & (l8 ? 7 : 3);
    else begin
      lo  = ((base & 3) + (b & 3)) % 4;
      nib = l8 ? ((base & 4) ^ (b & 4)) : (base & 4);
      lo  = lo | nib;
    end
    if (il && !l8) lo = lo | (base & 4);
    return (base & ~7) | lo;
  endfunction

  function automatic string mode_tag(bit l8, bit il);
    if (!l8) return il ? "R4" : "R3";
    return il ? "R6" : "R5";
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int  req_col;
  bit  req_l8, req_il;

  task automatic pick(int n);
    case (n)
      0: begin req_col = 10'h2D5; req_l8 = 1; req_il = 0; end
      1: begin req_col = 10'h1AE; req_l8 = 1; req_il = 1; end
      2: begin req_col = 10'h3FF; req_l8 = 0; req_il = 0; end
      3: begin req_col = 10'h006; req_l8 = 0; req_il = 1; end
      default: begin
        req_col = int'($urandom % (1 << COL_W));
        req_l8  = 1'($urandom % 2);
        req_il  = 1'($urandom % 2);
      end
    endcase
  endtask

  task automatic drive_req();
    start  = 1'b1;
    col_in = COL_W'(req_col);
    len8   = req_l8;
    ilv    = req_il;
  endtask

  initial begin
    int  cur_col;
    bit  cur_l8, cur_il, chained, junk_prev;
    int  blen, sh;
    void'($urandom(32'd4242));
    start = 0; col_in = '0; len8 = 0; ilv = 0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 valid in reset", int'(valid), 0);
    check("R1 last in reset", int'(last), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", int'(valid), 0);
    check("R1 last after reset", int'(last), 0);
    chained = 1'b0;
    pick(0);
    drive_req();
    for (int n = 0; n < NB; n++) begin
      cur_col = req_col; cur_l8 = req_l8; cur_il = req_il;
      blen = cur_l8 ? 8 : 4;
      sh   = cur_l8 ? 3 : 2;
      junk_prev = 1'b0;
      for (int b = 0; b < blen; b++) begin
        @(negedge clk);
        check((b == 0) ? (chained ? "R9 valid" : "R2 valid") : "R8 valid", int'(valid), 1);
        if (b == 0)
          check(chained ? "R9 first col" : "R2 first col", int'(col_out), cur_col);
        check(junk_prev ? "R10 col" : mode_tag(cur_l8, cur_il), int'(col_out),
              exp_col(cur_col, cur_l8, cur_il, b));
        check("R7 block", int'(col_out) >> sh, cur_col >> sh);
        check("R8 last", int'(last), (b == blen - 1) ? 1 : 0);
        if (b < blen - 1) begin
          junk_prev = ($urandom % 3) == 0;
          if (junk_prev) begin
            start  = 1'b1;
            col_in = COL_W'($urandom);
            len8   = 1'($urandom % 2);
            ilv    = 1'($urandom % 2);
          end else start = 1'b0;
        end else if (n == NB - 1) begin
          start = 1'b0; chained = 1'b0;
        end else begin
          pick(n + 1);
          chained = ($urandom % 2) == 1;
          if (chained) drive_req();
          else start = 1'b0;
        end
      end
      if (!chained) begin
        @(negedge clk);
        check("R8 idle after last", int'(valid), 0);
        if (n < NB - 1) drive_req();
      end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule